// File: doc/BRIEF.md
# Dual-Mode Wordline and Cell-Pairing Controller

This block turns memory commands into wordline and pairing strobes for an array that works in one of two reliability modes. Each row has two wordlines, A and B, and an active-low pairing strobe. In normal mode every cell stores its own bit. The A and B lines reach the two halves of a row, and the lowest address bit picks the half. In dependable mode two adjacent cells are tied together to keep one bit. A write then raises both lines of the row at once, a read raises only line A, and the pairing strobe stays low in every cycle, idle cycles included, so the joined cells keep their charge.

A command is given as an operation (idle, read or write), a bank number, a row address whose lowest bit is the half select, and write data. A command is taken when `cmd_valid` and `cmd_ready` are both high. One cycle later the chosen wordlines pulse for one cycle and a response comes out with read data and an error flag. A mode request is taken only when no command is being accepted. The controller drops `cmd_ready` for the cycle in which the requested mode differs from the present one, and the new mode applies from the next edge. A behavioural word store sits behind the wordlines, so the bench can check that dependable mode halves the capacity and that data survives a mode change. Columns are bit-interleaved, which means neighbouring cells of a row belong to different words. This affects only the physical layout and does not change the logic here. The array dimensions are parameters. The physical array has nine banks of 512 rows and 128 columns, and the defaults use fewer rows so the structure stays small.

Top module: `dmw_ctrl`

## Requirements
- R1: After reset the mode is normal, every wordline is low, every pairing strobe is high, `rsp_valid` is low and `cmd_ready` is high while `mode_req` is 0.
- R2: In normal mode (mode 0), an accepted read or write with no error raises exactly one wordline in the cycle after acceptance, for one cycle. Address bit 0 = 0 selects line A of the row and 1 selects line B. Flat line index = bank*ROWS + address[ROW_W:1].
- R3: In dependable mode (mode 1), an accepted write with no error raises lines A and B of the addressed row together, in the cycle after acceptance.
- R4: In dependable mode, an accepted read with no error raises line A of the addressed row and leaves every B line low.
- R5: Pairing strobes are all high while the mode is normal and all low while the mode is dependable, in idle cycles as well as in access cycles.
- R6: In dependable mode an access with address bit 0 = 1 returns `rsp_err` = 1 and `rsp_rdata` = 0, raises no wordline and leaves the store unchanged.
- R7: An access to a bank number at or above NUM_BANKS returns `rsp_err` = 1 and raises no wordline.
- R8: When `mode_req` differs from the present mode, `cmd_ready` is low in that cycle, so no command is taken. The new mode applies from the next clock edge.
- R9: At most one row of the whole array has any wordline high in any cycle, and only in the addressed bank.
- R10: A normal-mode read returns the word last written to that half of the row. A dependable write stores the word into both halves. A dependable read returns half A. Stored words survive mode changes.
- R11: Each accepted read or write gives exactly one `rsp_valid` pulse in the next cycle, with `rsp_rdata` = 0 for writes. An accepted idle operation (op code 0; read = 1, write = 2) gives no response and raises no wordline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req | input | 1 | Requested mode: 0 normal, 1 dependable |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 idle, 1 read, 2 write |
| cmd_bank | input | BANK_W (4) | Bank number |
| cmd_addr | input | ROW_W+1 (5) | Row in bits [ROW_W:1], half select in bit 0 |
| cmd_wdata | input | WORD_W (8) | Write word |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | WORD_W (8) | Read word |
| wl_a | output | NUM_BANKS*ROWS (144) | Line A of every row, index bank*ROWS+row |
| wl_b | output | NUM_BANKS*ROWS (144) | Line B of every row |
| pair_n | output | NUM_BANKS*ROWS (144) | Active-low pairing strobe of every row |

## Verification
If the mode register is wrong, the effect shows one cycle after the next access. A dependable write then raises only one line, or a normal access raises both, and the pairing strobes take the wrong level on the very next cycle. If the decoded row or half is wrong, a wordline pulses at the wrong flat index. If the store is wrong, a later read returns the wrong word, possibly several commands afterwards and across a mode change. A response with a wrong error flag shows up at once, in the single response cycle.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Line selection {B, A} for one access.
  function automatic logic [1:0] f_lines(input logic dep, input logic [1:0] op,
                                         input logic half);
    logic [1:0] s;
    s = 2'b00;
    if (op == OP_WRITE) s = dep ? 2'b11 : (half ? 2'b10 : 2'b01);
    else if (op == OP_READ) s = dep ? 2'b01 : (half ? 2'b10 : 2'b01);
    return s;
  endfunction

  // Refusal rule: bank out of range, or half B addressed while paired.
  function automatic logic f_bad(input logic dep, input logic half,
                                 input int unsigned bank, input int unsigned nb);
    return (bank >= nb) || (dep && half);
  endfunction

endpackage

// File: rtl/dmw_decode.sv
module dmw_decode #(
  parameter int NUM_BANKS = 9,
  parameter int ROWS      = 16,
  parameter int BANK_W    = 4,
  parameter int ROW_W     = 4,
  parameter int IDX_W     = 8
) (
  input  logic              dep,
  input  logic [1:0]        op,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W:0]    addr,
  output logic              bad,
  output logic [1:0]        sel,
  output logic [IDX_W-1:0]  idx
);
  import dmw_pkg::*;

  logic [ROW_W-1:0] row;
  logic             half;

  assign row  = addr[ROW_W:1];
  assign half = addr[0];
  assign bad  = (op != OP_IDLE) && f_bad(dep, half, int'(unsigned'(bank)), NUM_BANKS);
  assign sel  = bad ? 2'b00 : f_lines(dep, op, half);
  assign idx  = bad ? '0 : IDX_W'(int'(unsigned'(bank)) * ROWS + int'(unsigned'(row)));

endmodule

// File: rtl/dmw_wl_drive.sv
module dmw_wl_drive #(
  parameter int LINES = 144,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       sel,
  input  logic             mode_d,
  output logic [LINES-1:0] wl_a,
  output logic [LINES-1:0] wl_b,
  output logic [LINES-1:0] pair_n
);
  for (genvar i = 0; i < LINES; i++) begin : g_row
    logic a_q, b_q, p_q;
    logic hit;
    assign hit = fire && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= 1'b0;
        b_q <= 1'b0;
        p_q <= 1'b1;
      end else begin
        a_q <= hit && sel[0];
        b_q <= hit && sel[1];
        p_q <= ~mode_d;
      end
    end
    assign wl_a[i]   = a_q;
    assign wl_b[i]   = b_q;
    assign pair_n[i] = p_q;
  end

endmodule

// File: rtl/dmw_store.sv
module dmw_store #(
  parameter int LINES  = 144,
  parameter int IDX_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int SLOTS = 2 * LINES;

  logic [WORD_W-1:0] mem [SLOTS];
  int unsigned base;

  assign base  = 2 * int'(unsigned'(idx));
  assign rdata = (sel == 2'b10) ? mem[base + 1] : mem[base];

  always_ff @(posedge clk) begin
    if (we && sel[0]) mem[base]     <= wdata;
    if (we && sel[1]) mem[base + 1] <= wdata;
  end

endmodule

// File: rtl/dmw_ctrl.sv
module dmw_ctrl #(
  parameter int NUM_BANKS = 9,
  parameter int ROWS      = 16,
  parameter int WORD_W    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(ROWS),
  localparam int LINES    = NUM_BANKS * ROWS,
  localparam int IDX_W    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_req,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W:0]    cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [LINES-1:0]  wl_a,
  output logic [LINES-1:0]  wl_b,
  output logic [LINES-1:0]  pair_n
);
  import dmw_pkg::*;

  logic              mode_q;
  logic              switch_now;
  logic              mode_d;
  logic              acc;
  logic              op_live;
  logic              bad;
  logic              fire;
  logic [1:0]        sel;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] rd_word;

  assign switch_now = (mode_req != mode_q);
  assign mode_d     = switch_now ? mode_req : mode_q;
  assign cmd_ready  = !switch_now;
  assign acc        = cmd_valid && cmd_ready;
  assign op_live    = acc && (cmd_op != OP_IDLE);
  assign fire       = op_live && !bad;

  dmw_decode #(
    .NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .IDX_W(IDX_W)
  ) u_dec (
    .dep(mode_q), .op(cmd_op), .bank(cmd_bank), .addr(cmd_addr),
    .bad(bad), .sel(sel), .idx(idx)
  );

  dmw_wl_drive #(.LINES(LINES), .IDX_W(IDX_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .fire(fire), .idx(idx), .sel(sel),
    .mode_d(mode_d), .wl_a(wl_a), .wl_b(wl_b), .pair_n(pair_n)
  );

  dmw_store #(.LINES(LINES), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(fire && (cmd_op == OP_WRITE)), .idx(idx), .sel(sel),
    .wdata(cmd_wdata), .rdata(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      mode_q    <= mode_d;
      rsp_valid <= op_live;
      rsp_err   <= op_live && bad;
      rsp_rdata <= (fire && (cmd_op == OP_READ)) ? rd_word : '0;
    end
  end

endmodule

// File: rtl/dmw_ctrl_chk.sv
module dmw_ctrl_chk #(
  parameter int LINES = 144
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_req,
  input logic             mode_q,
  input logic             switch_now,
  input logic             cmd_ready,
  input logic             acc,
  input logic             op_live,
  input logic             bad,
  input logic [1:0]       cmd_op,
  input logic             rsp_valid,
  input logic [LINES-1:0] wl_a,
  input logic [LINES-1:0] wl_b,
  input logic [LINES-1:0] pair_n
);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req != mode_q) |-> !cmd_ready);

  p_mode_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    switch_now |=> (mode_q == $past(mode_req)));

  p_pair_dep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (pair_n == '0));

  p_pair_norm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (pair_n == '1));

  p_norm_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_live && !bad && !mode_q) |=> ($countones({wl_a, wl_b}) == 1));

  p_dep_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_live && !bad && mode_q && cmd_op == 2'd2) |=> ((wl_a != '0) && (wl_a == wl_b)));

  p_dep_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_live && !bad && mode_q && cmd_op == 2'd1) |=> ((wl_a != '0) && (wl_b == '0)));

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_live && bad) |=> ((wl_a == '0) && (wl_b == '0)));

  p_one_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wl_a | wl_b) <= 1);

  p_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_live |=> rsp_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_live) |=> (!rsp_valid && wl_a == '0 && wl_b == '0));

  p_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !switch_now);

endmodule

bind dmw_ctrl dmw_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_q(mode_q),
  .switch_now(switch_now), .cmd_ready(cmd_ready), .acc(acc),
  .op_live(op_live), .bad(bad), .cmd_op(cmd_op), .rsp_valid(rsp_valid),
  .wl_a(wl_a), .wl_b(wl_b), .pair_n(pair_n)
);

// File: tb/tb_dmw_ctrl.sv
module tb_dmw_ctrl;
  localparam int NB = 9;
  localparam int RW = 16;
  localparam int WW = 8;
  localparam int BW = $clog2(NB);
  localparam int RB = $clog2(RW);
  localparam int NL = NB * RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_req = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [BW-1:0] cmd_bank = '0;
  logic [RB:0] cmd_addr = '0;
  logic [WW-1:0] cmd_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [WW-1:0] rsp_rdata;
  logic [NL-1:0] wl_a, wl_b, pair_n;

  int checks = 0;
  int errors = 0;
  bit tb_mode = 1'b0;
  logic [WW-1:0] model [2*NL];
  logic [WW:0] expq [$];

  always #5 clk = ~clk;

  dmw_ctrl #(.NUM_BANKS(NB), .ROWS(RW), .WORD_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .wl_a(wl_a), .wl_b(wl_b),
    .pair_n(pair_n)
  );

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a response appears.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && rsp_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, "R11 unexpected response", {rsp_err, rsp_rdata}, 0);
        end else begin
          logic [WW:0] e;
          e = expq.pop_front();
          check({rsp_err, rsp_rdata} == e, "R10/R11 response {err,data}",
                {rsp_err, rsp_rdata}, e);
        end
      end
    end
  end

  // Driver: one command, then checks the wordline pulse that follows.
  task automatic issue(input logic [1:0] op, input int bank, input int row,
                       input bit half, input logic [WW-1:0] d, input string req);
    logic [NL-1:0] ea, eb;
    bit bad;
    int li;
    ea = '0; eb = '0;
    bad = (op != 2'd0) && ((bank >= NB) || (tb_mode && half));
    li = bank * RW + row;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = BW'(bank);
    cmd_addr = {RB'(row), half}; cmd_wdata = d;
    if (op != 2'd0) begin
      if (bad) expq.push_back({1'b1, {WW{1'b0}}});
      else if (op == 2'd2) expq.push_back({1'b0, {WW{1'b0}}});
      else expq.push_back({1'b0, tb_mode ? model[2*li] : model[2*li + int'(half)]});
    end
    if (op != 2'd0 && !bad) begin
      if (tb_mode) begin
        ea[li] = 1'b1;
        if (op == 2'd2) begin
          eb[li] = 1'b1;
          model[2*li] = d; model[2*li+1] = d;
        end
      end else begin
        if (half) eb[li] = 1'b1; else ea[li] = 1'b1;
        if (op == 2'd2) model[2*li + int'(half)] = d;
      end
    end
    #1;
    check(cmd_ready == 1'b1, {req, " ready"}, cmd_ready, 1);
    @(posedge clk); #2;
    check(wl_a == ea, {req, " line A"}, wl_a, ea);
    check(wl_b == eb, {req, " line B"}, wl_b, eb);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    @(posedge clk); #2;
    check((wl_a | wl_b) == '0, {req, " single-cycle pulse"}, wl_a | wl_b, 0);
  endtask

  task automatic switch_mode(input bit m);
    @(negedge clk);
    mode_req = m;
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_bank = '0; cmd_addr = '0; cmd_wdata = 8'hEE;
    #1;
    check(cmd_ready == 1'b0, "R8 ready low during switch", cmd_ready, 0);
    @(posedge clk); #2;
    check((wl_a | wl_b) == '0, "R8 stalled command raised no line", wl_a | wl_b, 0);
    check(pair_n == (m ? '0 : '1), "R5 pairing follows new mode", pair_n, m ? '0 : '1);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    tb_mode = m;
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(wl_a == '0 && wl_b == '0, "R1 lines low in reset", wl_a | wl_b, 0);
    check(pair_n == '1, "R1 pairing high in reset", pair_n, '1);
    check(rsp_valid == 1'b0, "R1 no response in reset", rsp_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    check(pair_n == '1, "R1 normal mode after reset", pair_n, '1);

    // Normal mode: separate halves
    issue(2'd2, 0, 3, 1'b0, 8'h15, "R2 write half A");
    issue(2'd2, 0, 3, 1'b1, 8'hA7, "R2 write half B");
    issue(2'd2, 8, 15, 1'b1, 8'h3C, "R9 write last bank last row");
    issue(2'd2, 2, 1, 1'b0, 8'h11, "R2 write b2 r1");
    issue(2'd1, 0, 3, 1'b0, 8'h00, "R10 read half A");
    issue(2'd1, 0, 3, 1'b1, 8'h00, "R10 read half B");
    issue(2'd1, 8, 15, 1'b1, 8'h00, "R10 read last row");
    issue(2'd0, 1, 2, 1'b0, 8'h00, "R11 idle operation");
    issue(2'd2, 12, 0, 1'b0, 8'h55, "R7 bank out of range");

    // Dependable mode
    switch_mode(1'b1);
    repeat (3) begin
      @(posedge clk); #2;
      check(pair_n == '0, "R5 pairing held in standby", pair_n, 0);
    end
    issue(2'd1, 0, 3, 1'b0, 8'h00, "R4 read after switch, R10 retention");
    issue(2'd2, 2, 1, 1'b0, 8'h96, "R3 paired write");
    issue(2'd1, 2, 1, 1'b0, 8'h00, "R4 paired read");
    issue(2'd2, 2, 1, 1'b1, 8'h44, "R6 half B refused on write");
    issue(2'd1, 2, 1, 1'b1, 8'h00, "R6 half B refused on read");
    issue(2'd1, 2, 1, 1'b0, 8'h00, "R6 store untouched");
    issue(2'd1, 10, 0, 1'b0, 8'h00, "R7 bad bank while paired");

    // Back to normal: both halves hold the paired word
    switch_mode(1'b0);
    issue(2'd1, 2, 1, 1'b1, 8'h00, "R10 paired write reached half B");
    issue(2'd1, 0, 3, 1'b1, 8'h00, "R10 half B survived two switches");
    @(posedge clk); #2;
    check(pair_n == '1, "R5 pairing released in normal", pair_n, '1);
    repeat (3) @(posedge clk);
    check(expq.size() == 0, "R11 all responses seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule